// File: doc/BRIEF.md
# MAC Address Table Host Access Engine

This block holds the address table of a small Ethernet switch and lets a host manage it through a few registers. The host places a 48-bit station address and its control bits (egress port, static, valid) in two staging registers. It then raises a bit in the command register. One command inserts, updates or removes the entry. Two other commands step through the table and return occupied entries one at a time. The host collects each entry from two result registers, and every returned entry carries either a found flag or an end-of-table flag.

The register port is a plain synchronous bus. A write takes effect at the clock edge where the write enable is high. A read returns the addressed register combinationally and changes no state. A make-entry is done with a single-cycle parallel lookup. A scan checks one slot per clock. A make-entry that arrives while a scan is running is held back until the scan finishes. The host sees this through a pending bit in the status register.

Register offsets: 0 staging low, 1 staging high, 2 command, 3 status, 4 result low, 5 result high.

Top module: `mac_table_host`

## Requirements
- R1: A 0-to-1 change of command bit 2 (offset 2) starts a make-entry. The entry is built from staging low (address bits 31:0) and staging high: address bits 47:32 in bits 15:0, port in bits 17:16, static in bit 24, valid in bit 26. A later scan can read the stored entry back.
- R2: Status bit 0 (offset 3) reads 1 in the cycle after the make-entry command is accepted. When no scan is running, it reads 0 one cycle later.
- R3: A make-entry whose address matches an occupied slot rewrites that slot and creates no second copy.
- R4: A make-entry with valid and static both 0 frees the slot that holds the matching address. If no slot matches, it does nothing.
- R5: A 0-to-1 change of command bit 1 (get-first) clears both flags and the result words at the accepting edge. From the next edge on, it checks slots from index 0, one slot per clock.
- R6: A 0-to-1 change of command bit 0 (get-next) checks slots starting just after the slot that was last returned.
- R7: Result high bit 26 marks a returned entry, with its address, port and static bit shown in the same layout as staging. Bit 31 marks end-of-table once the check goes past the last slot. The two flags are never set together.
- R8: If the table is full, a make-entry for a new address is dropped and status bit 1 is set. Bit 1 stays set until reset.
- R9: A command bit that is already 1 and is written as 1 again starts nothing.
- R10: A make-entry issued during a scan keeps status bit 0 set until the scan ends. It executes one clock after the scan ends.
- R11: Reads have no side effects. Writes to the status and result offsets are ignored. Undefined bits read 0.
- R12: A new address goes into the lowest free slot, and scans return entries in ascending slot order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write enable |
| busAddr | input | 3 | Register offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |

## Verification
The assertions check the following on every cycle:
- The two result flags are never set together.
- Accepting a command sets the pending flag and clears the flags.
- The pending flag holds while a scan runs and clears once the update is done.
- A held command bit starts nothing.
- A capture only ever takes an occupied slot.
- A delete really frees the slot it hit.
- The overflow flag stays set.

Only the bench's scenarios can show the table-level behaviour:
- Overwrite without a duplicate.
- Lowest-free placement.
- Scan order and resume point.
- Drop on a full table.
- Register layout and masking.

A behavioural model that steps every clock checks these, backed by named checks on each scan result.

// File: rtl/mac_table_pkg.sv
package mac_table_pkg;
  localparam int MAC_W  = 48;
  localparam int PORT_W = 2;
  localparam int DATA_W = 32;

  // register offsets
  localparam int REG_STAGE_LO = 0;
  localparam int REG_STAGE_HI = 1;
  localparam int REG_CMD      = 2;
  localparam int REG_STATUS   = 3;
  localparam int REG_RES_LO   = 4;
  localparam int REG_RES_HI   = 5;

  // command bits
  localparam int CMD_NEXT  = 0;
  localparam int CMD_FIRST = 1;
  localparam int CMD_MAKE  = 2;
  localparam int CMD_W     = 3;

  // high-word field positions
  localparam int POS_PORT   = 16;
  localparam int POS_STATIC = 24;
  localparam int POS_VALID  = 26;
  localparam int POS_END    = 31;

  typedef struct packed {
    logic              isValid;
    logic              isStatic;
    logic [PORT_W-1:0] port;
    logic [MAC_W-1:0]  mac;
  } tableEntry_t;

  typedef struct packed {
    logic commit;
    logic capture;
    logic clearResult;
  } tableStrobe_t;
endpackage

// File: rtl/mac_table_store.sv
module mac_table_store
  import mac_table_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tableStrobe_t      strobe,
  input  tableEntry_t       stageEntry,
  input  logic [PTR_W-1:0]  probeIdx,
  output logic              probeOcc,
  output logic              commitDropped,
  output logic [MAC_W-1:0]  resultMac,
  output logic [PORT_W-1:0] resultPort,
  output logic              resultStatic
);
  tableEntry_t slotMem [DEPTH];
  logic [DEPTH-1:0] occVec;
  logic matchHit, freeHit, isDelete;
  logic [IDX_W-1:0] matchIdx, freeIdx;

  for (genvar g = 0; g < DEPTH; g++) begin : gOcc
    assign occVec[g] = slotMem[g].isValid | slotMem[g].isStatic;
  end

  // parallel lookup: descending loop leaves the lowest index
  always_comb begin
    matchHit = 1'b0;
    matchIdx = '0;
    freeHit  = 1'b0;
    freeIdx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (occVec[i] && (slotMem[i].mac == stageEntry.mac)) begin
        matchHit = 1'b1;
        matchIdx = IDX_W'(i);
      end
      if (!occVec[i]) begin
        freeHit = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  assign isDelete      = !stageEntry.isValid && !stageEntry.isStatic;
  assign commitDropped = strobe.commit && !matchHit && !freeHit && !isDelete;
  assign probeOcc      = (probeIdx < PTR_W'(DEPTH)) && occVec[probeIdx[IDX_W-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) slotMem[i] <= '0;
      resultMac    <= '0;
      resultPort   <= '0;
      resultStatic <= 1'b0;
    end else begin
      if (strobe.commit) begin
        if (matchHit)
          slotMem[matchIdx] <= isDelete ? tableEntry_t'('0) : stageEntry;
        else if (freeHit && !isDelete)
          slotMem[freeIdx] <= stageEntry;
      end
      if (strobe.clearResult) begin
        resultMac    <= '0;
        resultPort   <= '0;
        resultStatic <= 1'b0;
      end else if (strobe.capture) begin
        resultMac    <= slotMem[probeIdx[IDX_W-1:0]].mac;
        resultPort   <= slotMem[probeIdx[IDX_W-1:0]].port;
        resultStatic <= slotMem[probeIdx[IDX_W-1:0]].isStatic;
      end
    end
  end

  assert_capture_occupied_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> probeOcc);

  assert_delete_frees_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && isDelete && matchHit) |=> !occVec[$past(matchIdx)]);
endmodule

// File: rtl/mac_table_ctrl.sv
module mac_table_ctrl
  import mac_table_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrite,
  input  logic [CMD_W-1:0] cmdData,
  input  logic             probeOcc,
  input  logic             commitDropped,
  output tableStrobe_t     strobe,
  output logic [PTR_W-1:0] probeIdx,
  output logic [CMD_W-1:0] cmdReg,
  output logic             makePending,
  output logic             overflowFlag,
  output logic             resultValid,
  output logic             endOfTable
);
  logic scanActive;
  logic [PTR_W-1:0] resumeIdx;
  logic makeStart, firstStart, nextStart, getStart, doMake, probeEnd;

  assign makeStart  = cmdWrite && cmdData[CMD_MAKE]  && !cmdReg[CMD_MAKE];
  assign firstStart = cmdWrite && cmdData[CMD_FIRST] && !cmdReg[CMD_FIRST];
  assign nextStart  = cmdWrite && cmdData[CMD_NEXT]  && !cmdReg[CMD_NEXT];
  assign getStart   = firstStart || nextStart;
  assign doMake     = makePending && !scanActive;
  assign probeEnd   = scanActive && (probeIdx >= PTR_W'(DEPTH));

  always_comb begin
    strobe.commit      = doMake;
    strobe.capture     = scanActive && !probeEnd && probeOcc && !getStart;
    strobe.clearResult = getStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg       <= '0;
      makePending  <= 1'b0;
      overflowFlag <= 1'b0;
      scanActive   <= 1'b0;
      probeIdx     <= '0;
      resumeIdx    <= '0;
      resultValid  <= 1'b0;
      endOfTable   <= 1'b0;
    end else begin
      if (cmdWrite) cmdReg <= cmdData;

      if (makeStart)   makePending <= 1'b1;
      else if (doMake) makePending <= 1'b0;

      if (doMake && commitDropped) overflowFlag <= 1'b1;

      if (getStart) begin
        scanActive  <= 1'b1;
        resultValid <= 1'b0;
        endOfTable  <= 1'b0;
        probeIdx    <= firstStart ? '0 : resumeIdx;
      end else if (scanActive) begin
        if (probeEnd) begin
          endOfTable <= 1'b1;
          scanActive <= 1'b0;
        end else if (probeOcc) begin
          resultValid <= 1'b1;
          scanActive  <= 1'b0;
          resumeIdx   <= probeIdx + PTR_W'(1);
        end else begin
          probeIdx <= probeIdx + PTR_W'(1);
        end
      end
    end
  end

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(resultValid && endOfTable));

  assert_pending_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    makeStart |=> makePending);

  assert_pending_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (makePending && !scanActive && !makeStart) |=> !makePending);

  assert_scan_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    getStart |=> (scanActive && !resultValid && !endOfTable));

  assert_make_waits_R10: assert property (@(posedge clk) disable iff (!rstN)
    (makePending && scanActive) |=> makePending);

  assert_no_retrigger_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && cmdReg[CMD_MAKE] && !makePending) |=> !makePending);

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);
endmodule

// File: rtl/mac_table_host.sv
module mac_table_host
  import mac_table_pkg::*;
#(
  parameter  int DEPTH  = 64,
  parameter  int ADDR_W = 3,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);
  tableEntry_t      stageEntry;
  tableStrobe_t     strobe;
  logic [PTR_W-1:0] probeIdx;
  logic [CMD_W-1:0] cmdReg;
  logic             probeOcc, commitDropped;
  logic             makePending, overflowFlag, resultValid, endOfTable;
  logic [MAC_W-1:0] resultMac;
  logic [PORT_W-1:0] resultPort;
  logic             resultStatic;
  logic             cmdWrite;

  assign cmdWrite = busWe && (busAddr == ADDR_W'(REG_CMD));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageEntry <= '0;
    end else if (busWe) begin
      if (busAddr == ADDR_W'(REG_STAGE_LO)) stageEntry.mac[31:0] <= busWdata;
      if (busAddr == ADDR_W'(REG_STAGE_HI)) begin
        stageEntry.mac[MAC_W-1:32] <= busWdata[MAC_W-33:0];
        stageEntry.port            <= busWdata[POS_PORT +: PORT_W];
        stageEntry.isStatic        <= busWdata[POS_STATIC];
        stageEntry.isValid         <= busWdata[POS_VALID];
      end
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(REG_STAGE_LO): busRdata = stageEntry.mac[31:0];
      ADDR_W'(REG_STAGE_HI): begin
        busRdata[MAC_W-33:0]         = stageEntry.mac[MAC_W-1:32];
        busRdata[POS_PORT +: PORT_W] = stageEntry.port;
        busRdata[POS_STATIC]         = stageEntry.isStatic;
        busRdata[POS_VALID]          = stageEntry.isValid;
      end
      ADDR_W'(REG_CMD):    busRdata[CMD_W-1:0] = cmdReg;
      ADDR_W'(REG_STATUS): busRdata[1:0] = {overflowFlag, makePending};
      ADDR_W'(REG_RES_LO): busRdata = resultMac[31:0];
      ADDR_W'(REG_RES_HI): begin
        busRdata[MAC_W-33:0]         = resultMac[MAC_W-1:32];
        busRdata[POS_PORT +: PORT_W] = resultPort;
        busRdata[POS_STATIC]         = resultStatic;
        busRdata[POS_VALID]          = resultValid;
        busRdata[POS_END]            = endOfTable;
      end
      default: busRdata = '0;
    endcase
  end

  mac_table_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdData(busWdata[CMD_W-1:0]),
    .probeOcc(probeOcc), .commitDropped(commitDropped), .strobe(strobe),
    .probeIdx(probeIdx), .cmdReg(cmdReg), .makePending(makePending),
    .overflowFlag(overflowFlag), .resultValid(resultValid), .endOfTable(endOfTable)
  );

  mac_table_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stageEntry(stageEntry),
    .probeIdx(probeIdx), .probeOcc(probeOcc), .commitDropped(commitDropped),
    .resultMac(resultMac), .resultPort(resultPort), .resultStatic(resultStatic)
  );
endmodule

// File: tb/mac_table_host_tb.sv
module mac_table_host_tb;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = 3'd5;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int checks = 0;
  int failures = 0;
  logic [31:0] gotLo, gotHi;

  always #2.5 clk = ~clk;

  mac_table_host #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  // ---------------- behavioural reference model ----------------
  bit          tOcc [DEPTH];
  logic [47:0] tMac [DEPTH];
  logic [1:0]  tPort [DEPTH];
  bit          tSt [DEPTH];
  logic [47:0] sMac, rMac;
  logic [1:0]  sPort, rPort;
  bit sSt, sVl, rSt, mPend, mOvf, mScan, mRv, mEot;
  logic [2:0]  mCmd;
  int mIdx, mResume;

  task automatic modelReset();
    for (int i = 0; i < DEPTH; i++) begin
      tOcc[i] = 0; tMac[i] = '0; tPort[i] = '0; tSt[i] = 0;
    end
    sMac = '0; sPort = '0; sSt = 0; sVl = 0; rMac = '0; rPort = '0; rSt = 0;
    mPend = 0; mOvf = 0; mScan = 0; mRv = 0; mEot = 0; mCmd = '0;
    mIdx = 0; mResume = 0;
  endtask

  task automatic modelStep(bit we, logic [2:0] a, logic [31:0] d);
    bit mkS, fS, nS, doMk, del;
    int hit, fr;
    mkS  = we && a == 3'd2 && d[2] && !mCmd[2];
    fS   = we && a == 3'd2 && d[1] && !mCmd[1];
    nS   = we && a == 3'd2 && d[0] && !mCmd[0];
    doMk = mPend && !mScan;
    if (fS || nS) begin
      mScan = 1; mRv = 0; mEot = 0; rMac = '0; rPort = '0; rSt = 0;
      mIdx = fS ? 0 : mResume;
    end else if (mScan) begin
      if (mIdx >= DEPTH) begin
        mEot = 1; mScan = 0;
      end else if (tOcc[mIdx]) begin
        mRv = 1; mScan = 0; rMac = tMac[mIdx]; rPort = tPort[mIdx]; rSt = tSt[mIdx];
        mResume = mIdx + 1;
      end else mIdx++;
    end
    if (doMk) begin
      del = !sVl && !sSt;
      hit = -1; fr = -1;
      for (int i = 0; i < DEPTH; i++) begin
        if (hit < 0 && tOcc[i] && tMac[i] == sMac) hit = i;
        if (fr < 0 && !tOcc[i]) fr = i;
      end
      if (hit >= 0) begin
        if (del) begin tOcc[hit] = 0; tMac[hit] = '0; tPort[hit] = '0; tSt[hit] = 0; end
        else begin tMac[hit] = sMac; tPort[hit] = sPort; tSt[hit] = sSt; end
      end else if (!del) begin
        if (fr >= 0) begin
          tOcc[fr] = 1; tMac[fr] = sMac; tPort[fr] = sPort; tSt[fr] = sSt;
        end else mOvf = 1;
      end
    end
    if (mkS) mPend = 1;
    else if (doMk) mPend = 0;
    if (we) begin
      if (a == 3'd0) sMac[31:0] = d;
      if (a == 3'd1) begin
        sMac[47:32] = d[15:0]; sPort = d[17:16]; sSt = d[24]; sVl = d[26];
      end
      if (a == 3'd2) mCmd = d[2:0];
    end
  endtask

  function automatic logic [31:0] expRead(logic [2:0] a);
    case (a)
      3'd0: return sMac[31:0];
      3'd1: return {5'b0, sVl, 1'b0, sSt, 6'b0, sPort, sMac[47:32]};
      3'd2: return {29'b0, mCmd};
      3'd3: return {30'b0, mOvf, mPend};
      3'd4: return rMac[31:0];
      3'd5: return {mEot, 4'b0, mRv, 1'b0, rSt, 6'b0, rPort, rMac[47:32]};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else modelStep(busWe, busAddr, busWdata);
  end

  // every-clock comparison against the model (R11 register view)
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (busRdata !== expRead(busAddr)) begin
        failures++;
        $display("FAIL R11 model compare addr=%0d actual=%h expected=%h",
                 busAddr, busRdata, expRead(busAddr));
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWe = 1'b0; busAddr = 3'd5;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    busAddr = a;
    @(negedge clk); v = busRdata;
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] hiWord(logic [47:0] mac, logic [1:0] port, bit st, bit vl);
    return {5'b0, vl, 1'b0, st, 6'b0, port, mac[47:32]};
  endfunction

  task automatic stage(logic [47:0] mac, logic [1:0] port, bit st, bit vl);
    wr(3'd0, mac[31:0]);
    wr(3'd1, hiWord(mac, port, st, vl));
  endtask

  task automatic makeEntry(logic [47:0] mac, logic [1:0] port, bit st, bit vl);
    stage(mac, port, st, vl);
    wr(3'd2, 32'h4);
    wr(3'd2, 32'h0);
  endtask

  task automatic getEntry(logic [31:0] cmd);
    logic [31:0] v;
    int n;
    wr(3'd2, cmd);
    wr(3'd2, 32'h0);
    n = 0;
    do begin
      rd(3'd5, v);
      n++;
    end while (!v[31] && !v[26] && n < 200);
    gotHi = v;
    rd(3'd4, gotLo);
  endtask

  task automatic expectEntry(string tag, logic [47:0] mac, logic [1:0] port, bit st);
    chk({tag, " high word"}, gotHi, hiWord(mac, port, st, 1'b1));
    chk({tag, " low word"}, gotLo, mac[31:0]);
  endtask

  task automatic expectEnd(string tag);
    chk({tag, " end-of-table"}, gotHi, 32'h8000_0000);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  localparam logic [47:0] MAC_A = 48'h0011_2233_4455;
  localparam logic [47:0] MAC_B = 48'h0022_3344_5566;
  localparam logic [47:0] MAC_C = 48'h0033_4455_6677;
  localparam logic [47:0] MAC_D = 48'h0044_5566_7788;
  localparam logic [47:0] MAC_E = 48'h0055_6677_8899;
  localparam logic [47:0] MAC_F = 48'h0077_8899_AABB;
  localparam logic [47:0] MAC_G = 48'h0066_1122_3344;
  localparam logic [47:0] MAC_H = 48'h00FF_0000_0001;

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // reset state
    rd(3'd3, v); chk("R11 status after reset", v, 32'h0);
    rd(3'd5, v); chk("R7 result high after reset", v, 32'h0);

    // R1/R2: make-entry and pending timing
    stage(MAC_A, 2'd1, 1'b0, 1'b1);
    wr(3'd2, 32'h4);
    rd(3'd3, v); chk("R2 pending after accept", v, 32'h1);
    rd(3'd3, v); chk("R2 pending cleared", v, 32'h0);
    wr(3'd2, 32'h0);
    makeEntry(MAC_B, 2'd2, 1'b1, 1'b1);
    makeEntry(MAC_C, 2'd3, 1'b0, 1'b1);

    // R5: flags cleared at the accepting edge
    wr(3'd2, 32'h2);
    rd(3'd5, v); chk("R5 flags clear while scanning", v, 32'h0);
    wr(3'd2, 32'h0);

    // R1/R5/R6/R7 scan of three entries
    getEntry(32'h2); expectEntry("R1 R5 first entry", MAC_A, 2'd1, 1'b0);
    getEntry(32'h1); expectEntry("R6 second entry", MAC_B, 2'd2, 1'b1);
    getEntry(32'h1); expectEntry("R6 third entry", MAC_C, 2'd3, 1'b0);
    getEntry(32'h1); expectEnd("R7 after last");
    rd(3'd4, v); chk("R7 result low cleared", v, 32'h0);

    // R3: overwrite keeps one copy
    makeEntry(MAC_A, 2'd2, 1'b0, 1'b1);
    getEntry(32'h2); expectEntry("R3 overwritten entry", MAC_A, 2'd2, 1'b0);
    getEntry(32'h1); expectEntry("R3 no duplicate", MAC_B, 2'd2, 1'b1);

    // R4: delete
    makeEntry(MAC_B, 2'd0, 1'b0, 1'b0);
    getEntry(32'h2); expectEntry("R4 first after delete", MAC_A, 2'd2, 1'b0);
    getEntry(32'h1); expectEntry("R4 deleted skipped", MAC_C, 2'd3, 1'b0);
    getEntry(32'h1); expectEnd("R4 end after delete");

    // R12: lowest free slot reused
    makeEntry(MAC_D, 2'd0, 1'b0, 1'b1);
    getEntry(32'h2); expectEntry("R12 slot0", MAC_A, 2'd2, 1'b0);
    getEntry(32'h1); expectEntry("R12 reused slot1", MAC_D, 2'd0, 1'b0);
    getEntry(32'h1); expectEntry("R12 slot2", MAC_C, 2'd3, 1'b0);

    // R9: held bit does not retrigger
    stage(MAC_E, 2'd1, 1'b1, 1'b1);
    wr(3'd2, 32'h4);
    rd(3'd3, v); rd(3'd3, v);
    stage(MAC_G, 2'd1, 1'b0, 1'b1);
    wr(3'd2, 32'h4);
    rd(3'd3, v); chk("R9 no pending on held bit", v, 32'h0);
    wr(3'd2, 32'h0);
    getEntry(32'h2); expectEntry("R9 scan slot0", MAC_A, 2'd2, 1'b0);
    getEntry(32'h1); getEntry(32'h1);
    getEntry(32'h1); expectEntry("R9 only first make stored", MAC_E, 2'd1, 1'b1);
    getEntry(32'h1); expectEnd("R9 no extra entry");

    // R10: make during a long scan waits
    getEntry(32'h2); getEntry(32'h1); getEntry(32'h1); getEntry(32'h1);
    stage(MAC_F, 2'd2, 1'b0, 1'b1);
    wr(3'd2, 32'h1);
    wr(3'd2, 32'h5);
    rd(3'd3, v); chk("R10 pending during scan", v, 32'h1);
    for (int i = 0; i < 10; i++) rd(3'd3, v);
    chk("R10 pending still held", v, 32'h1);
    do rd(3'd5, v); while (!v[31] && !v[26]);
    chk("R10 scan ends at end-of-table", v, 32'h8000_0000);
    rd(3'd3, v); chk("R10 make done after scan", v, 32'h0);
    wr(3'd2, 32'h0);
    getEntry(32'h2); getEntry(32'h1); getEntry(32'h1); getEntry(32'h1);
    getEntry(32'h1); expectEntry("R10 R12 deferred entry slot4", MAC_F, 2'd2, 1'b0);

    // R8: fill and overflow
    for (int i = 0; i < DEPTH - 5; i++)
      makeEntry(48'h0A00_0000_0000 + 48'(i), 2'd0, 1'b0, 1'b1);
    rd(3'd3, v); chk("R8 no overflow when exactly full", v, 32'h0);
    makeEntry(MAC_H, 2'd1, 1'b0, 1'b1);
    rd(3'd3, v); chk("R8 overflow set", v, 32'h2);
    makeEntry(MAC_A, 2'd3, 1'b0, 1'b1);
    rd(3'd3, v); chk("R8 overflow sticky", v, 32'h2);

    // R11: masking, read-only, no read side effects
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R11 staging high mask", v, 32'h0503_FFFF);
    rd(3'd5, v);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v2); chk("R11 result write ignored", v2, v);
    wr(3'd3, 32'h0);
    rd(3'd3, v); chk("R11 status write ignored", v, 32'h2);
    rd(3'd3, v2); chk("R11 read has no side effect", v2, v);

    summary();
    $finish;
  end
endmodule